// File: doc/BRIEF.md
# Prescaled Auto-Reload Tick Timer

The block produces a periodic tick from a slow reference. Everything runs on one system clock. The 32.768 kHz reference comes in as a one-cycle enable strobe (`ref_stb`). A power-of-two prescaler thins that strobe by 2^N, where N runs from 0 to 5. The thinned strobe (`pre_stb`) decrements a 16-bit down-counter. When the counter is at zero on a prescaled strobe, it reloads from a programmable reload value and raises `tick` for that one system cycle. Both `pre_stb` and `tick` are exported, so a neighbouring watchdog can use either one as its time base.

Software reaches the block through a small write port and a combinational read port. There are three registers:

| Address | Contents |
|---|---|
| 0 | Prescale exponent, bits 2:0 |
| 1 | Reload value, bits 15:0 |
| 2 | Control; bit 0 is the restart command |

A new reload value is picked up only at the next wrap. The restart bit forces a reload on the next prescaled strobe, then clears itself.

Top module: `lf_tick_timer`

## Requirements
- R1: `pre_stb` is high only in a cycle where `ref_stb` is high. With exponent N it is high on every 2^N-th reference strobe, counting strobes from reset, so with N=0 it follows `ref_stb` exactly.
- R2: Writing a value above 5 to address 0 stores 5. Writing a value from 0 to 5 stores that value. Address 0 reads back the stored exponent.
- R3: After reset, address 0 reads 0, address 1 reads 0xFFFF and address 2 reads 0. `pre_stb` and `tick` are low. The counter holds 0xFFFF, so no tick appears in the first prescaled strobes.
- R4: On each prescaled strobe the counter decrements when nonzero and reloads when zero. The tick period is therefore (reload + 1) prescaled strobes.
- R5: `tick` is high for exactly one system cycle. That cycle is the prescaled strobe at which the count is zero, and `tick` is low in the next cycle when no strobe follows.
- R6: Writing address 2 with bit 0 set makes bit 0 of address 2 read 1. Without a prescaled strobe the bit stays 1. At the next prescaled strobe the counter loads the reload value, with no tick if the count was nonzero, and the bit reads 0 afterwards.
- R7: Writing address 1 leaves the running count undisturbed. The current period completes with the old value, and the new value governs the periods after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_stb | input | 1 | One-cycle strobe at the 32.768 kHz reference rate |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| pre_stb | output | 1 | Prescaled enable strobe |
| tick | output | 1 | One-cycle tick at each counter wrap |

## Verification
`pre_stb` and `tick` are combinational from the registered state and appear in the same cycle as the reference strobe that causes them. The bench raises `ref_stb` for one cycle at a falling edge and samples both outputs shortly after, before the rising edge that updates the count. It samples `tick` again one cycle later to confirm it has dropped.

Register writes take effect at the rising edge that ends the write cycle. Reads are combinational, so read-backs are sampled one settle delay after the address is set. Tick positions are predicted by counting prescaled strobes from a restart, using the period rule and the rule that a new reload value takes effect only at the next wrap.

// File: rtl/lft_pkg.sv
// Shared definitions for the prescaled tick timer: register map addresses.
package lft_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_EXP    = 2'd0,
        REG_RELOAD = 2'd1,
        REG_CTRL   = 2'd2
    } reg_addr_e;
endpackage

// File: rtl/lft_prescaler.sv
// Power-of-two strobe divider.
// Counts reference strobes with a free-running counter. It passes one strobe
// out of every 2^exp, namely the one that completes a group of 2^exp strobes
// counted from reset.
// Assumes ref_stb is a single-cycle strobe and exp never exceeds MAX_EXP.
module lft_prescaler #(
    parameter int MAX_EXP = 5,
    parameter int EXP_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_stb,
    input  logic [EXP_W-1:0] exp,
    output logic             pre_stb
);
    localparam int PCNT_W = (MAX_EXP > 0) ? MAX_EXP : 1;

    logic [PCNT_W-1:0] pcnt;
    logic [PCNT_W-1:0] mask;

    // Low exp bits of the strobe count that must all be ones.
    always_comb begin
        mask = PCNT_W'((32'd1 << exp) - 32'd1);
    end

    // Advance the strobe counter on every reference strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (ref_stb) begin
            pcnt <= pcnt + 1'b1;
        end
    end

    assign pre_stb = ref_stb && ((pcnt & mask) == mask);

    AST_EXP0_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (exp == '0) |-> (pre_stb == ref_stb)); // R1
endmodule

// File: rtl/lft_regs.sv
// Register file for the tick timer.
// Holds the prescale exponent (clamped to MAX_EXP), the reload value and the
// restart-pending flag. The flag is set by a control write with bit 0 high and
// cleared at the next prescaled strobe, when the counter performs the load.
// Assumes single-cycle writes; reads are combinational.
module lft_regs
    import lft_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int MAX_EXP = 5,
    parameter int EXP_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    input  logic              pre_stb,
    output logic [EXP_W-1:0]  exp,
    output logic [CNT_W-1:0]  reload,
    output logic              restart_pend
);
    logic wr_exp, wr_reload, wr_restart;

    // Decode the write strobes per register.
    always_comb begin
        wr_exp     = wr_en && (wr_addr == REG_EXP);
        wr_reload  = wr_en && (wr_addr == REG_RELOAD);
        wr_restart = wr_en && (wr_addr == REG_CTRL) && wr_data[0];
    end

    // Exponent register with saturation at MAX_EXP.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp <= '0;
        end else if (wr_exp) begin
            if (wr_data > CNT_W'(MAX_EXP)) exp <= EXP_W'(MAX_EXP);
            else                           exp <= wr_data[EXP_W-1:0];
        end
    end

    // Reload value register.
    always_ff @(posedge clk) begin
        if (!rst_n)         reload <= {CNT_W{1'b1}};
        else if (wr_reload) reload <= wr_data;
    end

    // Restart-pending flag: a new request wins over the clearing strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)          restart_pend <= 1'b0;
        else if (wr_restart) restart_pend <= 1'b1;
        else if (pre_stb)    restart_pend <= 1'b0;
    end

    // Read mux.
    always_comb begin
        case (rd_addr)
            REG_EXP:    rd_data = CNT_W'(exp);
            REG_RELOAD: rd_data = reload;
            REG_CTRL:   rd_data = CNT_W'(restart_pend);
            default:    rd_data = '0;
        endcase
    end

    AST_EXP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        exp <= EXP_W'(MAX_EXP)); // R2
    AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_pend && pre_stb && !wr_restart) |=> !restart_pend); // R6
    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_pend && !pre_stb) |=> restart_pend); // R6
endmodule

// File: rtl/lft_counter.sv
// Auto-reloading down-counter.
// On each prescaled strobe it decrements, or loads the reload value when the
// count is zero or a restart is pending. tick marks the strobe at which the
// count is zero.
// Assumes pre_stb is a single-cycle strobe.
module lft_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pre_stb,
    input  logic             restart_pend,
    input  logic [CNT_W-1:0] reload,
    output logic             tick
);
    logic [CNT_W-1:0] count;
    logic             at_zero;

    assign at_zero = (count == '0);

    // Count down on prescaled strobes; reload at wrap or on restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= {CNT_W{1'b1}};
        end else if (pre_stb) begin
            if (restart_pend || at_zero) count <= reload;
            else                         count <= count - 1'b1;
        end
    end

    assign tick = pre_stb && at_zero;

    AST_RELOAD_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_stb && at_zero) |=> (count == $past(reload))); // R4
    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_stb && !at_zero && !restart_pend) |=> (count == $past(count) - 1'b1)); // R4
    AST_RESTART_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_stb && restart_pend) |=> (count == $past(reload))); // R6
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pre_stb |=> $stable(count)); // R7
endmodule

// File: rtl/lf_tick_timer.sv
// Prescaled auto-reload tick timer, top level.
// Joins the prescaler, the register file and the down-counter, and exports
// the prescaled strobe and the tick for use as watchdog time bases.
// Assumes ref_stb is a single-cycle strobe in the clk domain.
module lf_tick_timer
    import lft_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int MAX_EXP = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_stb,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic              pre_stb,
    output logic              tick
);
    localparam int EXP_W = $clog2(MAX_EXP + 1);

    logic [EXP_W-1:0] exp;
    logic [CNT_W-1:0] reload;
    logic             restart_pend;

    lft_regs #(.CNT_W(CNT_W), .MAX_EXP(MAX_EXP), .EXP_W(EXP_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pre_stb(pre_stb), .exp(exp), .reload(reload),
        .restart_pend(restart_pend)
    );

    lft_prescaler #(.MAX_EXP(MAX_EXP), .EXP_W(EXP_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .exp(exp),
        .pre_stb(pre_stb)
    );

    lft_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .pre_stb(pre_stb),
        .restart_pend(restart_pend), .reload(reload), .tick(tick)
    );

    AST_TICK_WITH_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> pre_stb); // R5
    AST_PRE_NEEDS_REF: assert property (@(posedge clk) disable iff (!rst_n)
        pre_stb |-> ref_stb); // R1
endmodule

// File: tb/lf_tick_timer_test.sv
// Directed bench for lf_tick_timer: one task per scenario.
module lf_tick_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_stb = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        pre_stb, tick;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    lf_tick_timer uut (
        .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .pre_stb(pre_stb), .tick(tick)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [1:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    // One reference strobe; p/t sampled in the strobe cycle, ta one cycle later.
    task automatic ref_pulse(output bit p, output bit t, output bit ta);
        @(negedge clk);
        ref_stb = 1'b1;
        #1; p = pre_stb; t = tick;
        @(negedge clk);
        ref_stb = 1'b0;
        #1; ta = tick;
    endtask

    task automatic t_reset;
        int v; bit p, t, ta; int nt;
        do_read(2'd0, v); check("R3 exp after reset", v, 0);
        do_read(2'd1, v); check("R3 reload after reset", v, 16'hFFFF);
        do_read(2'd2, v); check("R3 ctrl after reset", v, 0);
        #1;
        check("R3 pre_stb idle", int'(pre_stb), 0);
        check("R1 no pre_stb without ref_stb", int'(pre_stb), 0);
        check("R3 tick idle", int'(tick), 0);
        nt = 0;
        for (int i = 0; i < 3; i++) begin
            ref_pulse(p, t, ta);
            if (t) nt++;
        end
        check("R3 no early tick from 0xFFFF", nt, 0);
    endtask

    task automatic t_prescale;
        bit p, t, ta; int np, last, bad;
        do_write(2'd0, 16'd0);
        np = 0;
        for (int i = 0; i < 4; i++) begin
            ref_pulse(p, t, ta);
            if (p) np++;
        end
        check("R1 exp0 passes every strobe", np, 4);
        do_write(2'd0, 16'd2);
        np = 0; last = -1; bad = 0;
        for (int i = 0; i < 16; i++) begin
            ref_pulse(p, t, ta);
            if (p) begin
                if (last >= 0 && i - last != 4) bad++;
                last = i; np++;
            end
        end
        check("R1 exp2 strobe count", np, 4);
        check("R1 exp2 strobe spacing", bad, 0);
    endtask

    task automatic t_clamp;
        int v;
        do_write(2'd0, 16'd7);
        do_read(2'd0, v); check("R2 exponent clamp", v, 5);
        do_write(2'd0, 16'd3);
        do_read(2'd0, v); check("R2 exponent in range", v, 3);
    endtask

    task automatic t_period;
        int v; bit p, t, ta;
        do_write(2'd0, 16'd0);
        do_write(2'd1, 16'd3);
        do_write(2'd2, 16'd1);
        do_read(2'd2, v); check("R6 restart pending reads 1", v, 1);
        ref_pulse(p, t, ta);
        do_read(2'd2, v); check("R6 restart self-clears", v, 0);
        for (int i = 1; i <= 8; i++) begin
            ref_pulse(p, t, ta);
            check($sformatf("R4 tick at strobe %0d", i), int'(t), (i % 4 == 0) ? 1 : 0);
            if (i == 4) check("R5 tick one cycle wide", int'(ta), 0);
        end
    endtask

    task automatic t_reload_change;
        bit p, t, ta;
        do_write(2'd1, 16'd1);
        for (int i = 1; i <= 6; i++) begin
            ref_pulse(p, t, ta);
            check($sformatf("R7 tick at strobe %0d", i), int'(t),
                  (i == 4 || i == 6) ? 1 : 0);
        end
    endtask

    task automatic t_restart_mid;
        bit p, t, ta; int nt;
        do_write(2'd1, 16'd5);
        do_write(2'd2, 16'd1);
        ref_pulse(p, t, ta);
        check("R6 restart load gives no tick", int'(t), 0);
        ref_pulse(p, t, ta);
        ref_pulse(p, t, ta);
        do_write(2'd2, 16'd1);
        ref_pulse(p, t, ta);
        check("R6 mid-count restart no tick", int'(t), 0);
        nt = 0;
        for (int i = 1; i <= 5; i++) begin
            ref_pulse(p, t, ta);
            if (t) nt++;
        end
        check("R6 no tick before full period", nt, 0);
        ref_pulse(p, t, ta);
        check("R6 tick after full reload period", int'(t), 1);
    endtask

    task automatic t_pend_hold;
        int v; bit p, t, ta; bit seen;
        do_write(2'd0, 16'd2);
        do_write(2'd2, 16'd1);
        repeat (5) @(negedge clk);
        do_read(2'd2, v); check("R6 pending held without strobe", v, 1);
        seen = 0;
        for (int i = 0; i < 4 && !seen; i++) begin
            ref_pulse(p, t, ta);
            if (p) seen = 1;
        end
        check("R6 prescaled strobe seen", int'(seen), 1);
        do_read(2'd2, v); check("R6 pending cleared by strobe", v, 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++; checks++;
                $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_prescale;
        t_clamp;
        t_period;
        t_reload_change;
        t_restart_mid;
        t_pend_hold;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule